// File: doc/BRIEF.md
# Active-Halt Power Mode Sequencer

This block sequences a small processor core into and out of its deepest sleep mode in which a real-time time base stays alive. When the core executes a halt instruction and the sleep mode is enabled, the sequencer stops the CPU clock. It also drops the clock enables of every peripheral except the wake-up timer and those peripherals that run from their own clock source. On the way in it pulses a strobe that clears the core's interrupt mask.

Only two events bring the core back. A wake-up interrupt from the timer restores the CPU clock on the next cycle and requests the interrupt vector at once. A reset request instead starts a fixed start-up wait of `DLY` cycles, 64 by default, and then requests the reset vector. If an interrupt is already pending when the halt instruction executes, the core does not sleep at all and is sent straight to the interrupt vector.

A halt executed while the watchdog is running produces a reset only when the watchdog-halt control bit is set. When the bit is clear, the core sleeps, and the watchdog, which keeps counting outside this block, still bounds the time spent asleep.

Top module: `ahalt_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cpu_clk_en` is 1, every bit of `periph_clk_en` is 1, and `clr_imask`, `vec_fetch` and `rst_out` are 0.
- R2: A `halt_exec` pulse with `ahalt_en`=1, no pending interrupt and no watchdog trip puts the block to sleep: `cpu_clk_en` reads 0 from the cycle after the sampling edge. With `ahalt_en`=0 the block stays running and `clr_imask` stays 0.
- R3: While the CPU clock is gated, `periph_clk_en` equals the keep mask: the bits of `KEEP_MASK` plus bit `TMR_IDX` are 1, and all other bits are 0. When the block runs again, all bits return to 1.
- R4: Entry to sleep gives `clr_imask`=1 for exactly one cycle, on the same cycle that `cpu_clk_en` first reads 0.
- R5: While asleep, pending flags on `irq_pend` are ignored: `cpu_clk_en` stays 0 and `vec_fetch` stays 0.
- R6: While asleep, a `tmr_wake_irq` sampled at an edge gives `cpu_clk_en`=1, `vec_fetch`=1 and `vec_sel`=0 (interrupt vector) on the very next cycle, with no added delay. `vec_fetch` lasts one cycle.
- R7: While asleep, a `rst_req` sampled at an edge starts the start-up wait. `vec_fetch` rises with `vec_sel`=1 (reset vector) exactly `DLY` edges later and lasts one cycle, and `cpu_clk_en` stays 0 until then.
- R8: A `rst_req` sampled during the start-up wait restarts it, so the reset vector fetch comes `DLY` edges after the latest request.
- R9: If `rst_req` and `tmr_wake_irq` are sampled at the same edge while asleep, the reset path wins: there is no interrupt fetch, and the reset fetch follows `DLY` edges later.
- R10: A `halt_exec` sampled with `ahalt_en`=1 while any interrupt is pending (`tmr_wake_irq` or any `irq_pend` bit) keeps `cpu_clk_en` at 1. On the next cycle it gives `clr_imask`=1, `vec_fetch`=1 and `vec_sel`=0.
- R11: A `halt_exec` with `wdg_active`=1 and `wdg_halt_rst`=0 never raises `rst_out`, and the block enters sleep. With `wdg_halt_rst`=1, `rst_out` pulses for one cycle and the block stays running.
- R12: A `rst_req` sampled while running leaves the block running, even when `halt_exec` is sampled at the same edge: `cpu_clk_en` stays 1, and `vec_fetch` and `clr_imask` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst | input | 1 | Synchronous active-high block reset |
| halt_exec | input | 1 | One-cycle strobe: halt instruction executed |
| ahalt_en | input | 1 | Active-halt mode enable |
| tmr_wake_irq | input | 1 | Wake-up interrupt from the selected timer |
| irq_pend | input | NIRQ | Other pending interrupt flags |
| rst_req | input | 1 | Reset request (wake source or restart) |
| wdg_active | input | 1 | Watchdog is running |
| wdg_halt_rst | input | 1 | Watchdog-halt control: 1 = halt gives a reset |
| periph_clk_en | output | NPER | Per-peripheral clock enables |
| cpu_clk_en | output | 1 | CPU clock enable |
| clr_imask | output | 1 | Strobe clearing the interrupt mask bit |
| vec_fetch | output | 1 | One-cycle vector fetch request |
| vec_sel | output | 1 | Vector selector: 0 interrupt, 1 reset |
| rst_out | output | 1 | Reset pulse for a halt with watchdog-halt set |

## Verification
Two pairs of events can fall on the same edge. In the first pair, a timer wake-up and a reset request both arrive while the block is asleep. The bench drives both on one cycle and judges that no interrupt fetch appears and that the reset fetch comes exactly `DLY` edges later. In the second pair, a halt instruction meets an interrupt that is already pending, or meets a reset request, on the same edge. The bench sees the first case as an immediate interrupt fetch with the CPU clock never dropping. It sees the second as the block simply staying in run.

// File: rtl/ahalt_pkg.sv
package ahalt_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_DLY  = 2'd2
  } ah_state_t;

  localparam logic VSEL_IRQ = 1'b0;
  localparam logic VSEL_RST = 1'b1;

endpackage

// File: rtl/ahalt_dly_cnt.sv
module ahalt_dly_cnt #(
  parameter int DLY = 64,
  parameter int CW  = $clog2(DLY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic last
);

  localparam logic [CW-1:0] LOADV = CW'(DLY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= LOADV;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // final step of the wait: the next tick takes the count to zero
  assign last = (cnt == CW'(1));

endmodule

// File: rtl/ahalt_pclk_gate.sv
module ahalt_pclk_gate #(
  parameter int               NPER = 8,
  parameter logic [NPER-1:0]  KEEP = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sleep_nxt,
  output logic [NPER-1:0] en
);

  for (genvar i = 0; i < NPER; i++) begin : g_bit
    if (KEEP[i]) begin : g_keep
      always_ff @(posedge clk) begin
        en[i] <= 1'b1;
      end
    end else begin : g_gate
      always_ff @(posedge clk) begin
        if (rst) en[i] <= 1'b1;
        else     en[i] <= ~sleep_nxt;
      end
    end
  end

endmodule

// File: rtl/ahalt_fsm.sv
module ahalt_fsm
  import ahalt_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            halt_exec,
  input  logic            ahalt_en,
  input  logic            tmr_wake_irq,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic            rst_req,
  input  logic            wdg_active,
  input  logic            wdg_halt_rst,
  input  logic            dly_last,
  output logic            dly_load,
  output logic            dly_tick,
  output logic            sleep_nxt,
  output ah_state_t       st,
  output logic            cpu_clk_en,
  output logic            clr_imask,
  output logic            vec_fetch,
  output logic            vec_sel,
  output logic            rst_out
);

  ah_state_t nxt;
  logic      clr_n, fetch_n, sel_n, rout_n;
  logic      wake_any, wdg_trip;

  assign wake_any = tmr_wake_irq | (|irq_pend);
  assign wdg_trip = wdg_active & wdg_halt_rst;

  always_comb begin
    nxt      = st;
    clr_n    = 1'b0;
    fetch_n  = 1'b0;
    sel_n    = vec_sel;
    rout_n   = 1'b0;
    dly_load = 1'b0;
    dly_tick = 1'b0;
    unique case (st)
      ST_RUN: begin
        if (!rst_req && halt_exec) begin
          if (wdg_trip) begin
            rout_n = 1'b1;
          end else if (ahalt_en) begin
            clr_n = 1'b1;
            if (wake_any) begin
              fetch_n = 1'b1;
              sel_n   = VSEL_IRQ;
            end else begin
              nxt = ST_HALT;
            end
          end
        end
      end
      ST_HALT: begin
        if (rst_req) begin
          nxt      = ST_DLY;
          dly_load = 1'b1;
        end else if (tmr_wake_irq) begin
          nxt     = ST_RUN;
          fetch_n = 1'b1;
          sel_n   = VSEL_IRQ;
        end
      end
      ST_DLY: begin
        if (rst_req) begin
          dly_load = 1'b1;
        end else begin
          dly_tick = 1'b1;
          if (dly_last) begin
            nxt     = ST_RUN;
            fetch_n = 1'b1;
            sel_n   = VSEL_RST;
          end
        end
      end
      default: nxt = ST_RUN;
    endcase
  end

  assign sleep_nxt = (nxt != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_RUN;
      cpu_clk_en <= 1'b1;
      clr_imask  <= 1'b0;
      vec_fetch  <= 1'b0;
      vec_sel    <= VSEL_IRQ;
      rst_out    <= 1'b0;
    end else begin
      st         <= nxt;
      cpu_clk_en <= ~sleep_nxt;
      clr_imask  <= clr_n;
      vec_fetch  <= fetch_n;
      vec_sel    <= sel_n;
      rst_out    <= rout_n;
    end
  end

endmodule

// File: rtl/ahalt_ctrl.sv
module ahalt_ctrl
  import ahalt_pkg::*;
#(
  parameter int              NPER      = 8,
  parameter int              NIRQ      = 4,
  parameter int              DLY       = 64,
  parameter int              TMR_IDX   = 0,
  parameter logic [NPER-1:0] KEEP_MASK = NPER'(8'h80)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            halt_exec,
  input  logic            ahalt_en,
  input  logic            tmr_wake_irq,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic            rst_req,
  input  logic            wdg_active,
  input  logic            wdg_halt_rst,
  output logic [NPER-1:0] periph_clk_en,
  output logic            cpu_clk_en,
  output logic            clr_imask,
  output logic            vec_fetch,
  output logic            vec_sel,
  output logic            rst_out
);

  localparam int              CW       = $clog2(DLY + 1);
  localparam logic [NPER-1:0] KEEP_ALL = KEEP_MASK | (NPER'(1) << TMR_IDX);

  logic      dly_load, dly_tick, dly_last, sleep_nxt;
  ah_state_t st;

  ahalt_fsm #(.NIRQ(NIRQ)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .halt_exec    (halt_exec),
    .ahalt_en     (ahalt_en),
    .tmr_wake_irq (tmr_wake_irq),
    .irq_pend     (irq_pend),
    .rst_req      (rst_req),
    .wdg_active   (wdg_active),
    .wdg_halt_rst (wdg_halt_rst),
    .dly_last     (dly_last),
    .dly_load     (dly_load),
    .dly_tick     (dly_tick),
    .sleep_nxt    (sleep_nxt),
    .st           (st),
    .cpu_clk_en   (cpu_clk_en),
    .clr_imask    (clr_imask),
    .vec_fetch    (vec_fetch),
    .vec_sel      (vec_sel),
    .rst_out      (rst_out)
  );

  ahalt_dly_cnt #(.DLY(DLY), .CW(CW)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .load (dly_load),
    .tick (dly_tick),
    .last (dly_last)
  );

  ahalt_pclk_gate #(.NPER(NPER), .KEEP(KEEP_ALL)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .sleep_nxt (sleep_nxt),
    .en        (periph_clk_en)
  );

endmodule

// File: rtl/ahalt_ctrl_chk.sv
module ahalt_ctrl_chk
  import ahalt_pkg::*;
#(
  parameter int              NPER     = 8,
  parameter int              DLY      = 64,
  parameter logic [NPER-1:0] KEEP_ALL = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            halt_exec,
  input logic            tmr_wake_irq,
  input logic            rst_req,
  input logic            wdg_halt_rst,
  input ah_state_t       st,
  input logic [NPER-1:0] periph_clk_en,
  input logic            cpu_clk_en,
  input logic            vec_fetch,
  input logic            vec_sel,
  input logic            rst_out
);

  localparam int DW = $clog2(DLY + 2) + 1;
  logic [DW-1:0] since_req;

  always_ff @(posedge clk) begin
    if (rst)                                       since_req <= '0;
    else if ((st == ST_HALT || st == ST_DLY) && rst_req) since_req <= DW'(1);
    else if (vec_fetch)                            since_req <= '0;
    else if (since_req != '0)                      since_req <= since_req + 1'b1;
  end

  // R3
  periph_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_clk_en |-> ((periph_clk_en & ~KEEP_ALL) == '0));

  // R6
  irq_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HALT && tmr_wake_irq && !rst_req) |=>
      (cpu_clk_en && vec_fetch && vec_sel == VSEL_IRQ));

  // R7
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |=> !vec_fetch);

  // R7
  rst_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_fetch && vec_sel == VSEL_RST) |-> (since_req == DW'(DLY + 1)));

  // R9
  rst_first_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_HALT || st == ST_DLY) && rst_req) |=> (!vec_fetch && !cpu_clk_en));

  // R11
  wdg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (halt_exec && !wdg_halt_rst) |=> !rst_out);

endmodule

bind ahalt_ctrl ahalt_ctrl_chk #(.NPER(NPER), .DLY(DLY), .KEEP_ALL(KEEP_ALL)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .halt_exec     (halt_exec),
  .tmr_wake_irq  (tmr_wake_irq),
  .rst_req       (rst_req),
  .wdg_halt_rst  (wdg_halt_rst),
  .st            (st),
  .periph_clk_en (periph_clk_en),
  .cpu_clk_en    (cpu_clk_en),
  .vec_fetch     (vec_fetch),
  .vec_sel       (vec_sel),
  .rst_out       (rst_out)
);

// File: tb/tb_ahalt_ctrl.sv
`timescale 1ns/1ps
module tb_ahalt_ctrl;

  localparam int              NPER = 8;
  localparam int              NIRQ = 4;
  localparam int              DLY  = 64;
  localparam logic [NPER-1:0] KEEP = 8'h81; // KEEP_MASK bit 7 plus timer bit 0

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            halt_exec = 0, ahalt_en = 0, tmr_wake_irq = 0, rst_req = 0;
  logic            wdg_active = 0, wdg_halt_rst = 0;
  logic [NIRQ-1:0] irq_pend = '0;
  logic [NPER-1:0] periph_clk_en;
  logic            cpu_clk_en, clr_imask, vec_fetch, vec_sel, rst_out;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  ahalt_ctrl #(.NPER(NPER), .NIRQ(NIRQ), .DLY(DLY), .TMR_IDX(0),
               .KEEP_MASK(8'h80)) dut (
    .clk(clk), .rst(rst), .halt_exec(halt_exec), .ahalt_en(ahalt_en),
    .tmr_wake_irq(tmr_wake_irq), .irq_pend(irq_pend), .rst_req(rst_req),
    .wdg_active(wdg_active), .wdg_halt_rst(wdg_halt_rst),
    .periph_clk_en(periph_clk_en), .cpu_clk_en(cpu_clk_en),
    .clr_imask(clr_imask), .vec_fetch(vec_fetch), .vec_sel(vec_sel),
    .rst_out(rst_out));

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drop_inputs();
    halt_exec = 0; tmr_wake_irq = 0; rst_req = 0; irq_pend = '0;
  endtask

  task automatic enter_halt();
    ahalt_en = 1; halt_exec = 1;
    step();
    drop_inputs();
  endtask

  // counts edges after the sampling edge until the reset-vector fetch
  task automatic count_to_fetch(input string req);
    int n = 0;
    int clk_seen = 0;
    while (!vec_fetch && n < 300) begin
      if (cpu_clk_en) clk_seen = 1;
      step();
      n++;
    end
    chk(req, "edges to reset fetch", n, DLY);
    chk(req, "vec_sel reset", vec_sel, 1);
    chk(req, "cpu clock held off during wait", clk_seen, 0);
    chk(req, "cpu clock back at fetch", cpu_clk_en, 1);
    step();
    chk(req, "fetch single cycle", vec_fetch, 0);
  endtask

  task automatic t_reset();
    chk("R1", "cpu_clk_en in reset", cpu_clk_en, 1);
    rst = 0;
    step();
    chk("R1", "cpu_clk_en", cpu_clk_en, 1);
    chk("R1", "periph_clk_en", periph_clk_en, 8'hFF);
    chk("R1", "clr/fetch/rst_out", {clr_imask, vec_fetch, rst_out}, 0);
  endtask

  task automatic t_disabled();
    ahalt_en = 0; halt_exec = 1;
    step();
    drop_inputs();
    chk("R2", "disabled halt keeps clock", cpu_clk_en, 1);
    chk("R2", "disabled halt no clr", clr_imask, 0);
  endtask

  task automatic t_enter_and_irq_exit();
    enter_halt();
    chk("R2", "clock gated", cpu_clk_en, 0);
    chk("R4", "clr strobe", clr_imask, 1);
    chk("R3", "periph keep mask", periph_clk_en, KEEP);
    step();
    chk("R4", "clr one cycle", clr_imask, 0);
    irq_pend = 4'b0110;
    step(); step();
    chk("R5", "other irq ignored clk", cpu_clk_en, 0);
    chk("R5", "other irq ignored fetch", vec_fetch, 0);
    irq_pend = '0; tmr_wake_irq = 1;
    step();
    drop_inputs();
    chk("R6", "wake clock", cpu_clk_en, 1);
    chk("R6", "wake fetch", vec_fetch, 1);
    chk("R6", "wake sel irq", vec_sel, 0);
    chk("R3", "periph restored", periph_clk_en, 8'hFF);
    step();
    chk("R6", "fetch one cycle", vec_fetch, 0);
  endtask

  task automatic t_rst_exit();
    enter_halt();
    step();
    rst_req = 1;
    step();
    drop_inputs();
    chk("R7", "no fetch at request", vec_fetch, 0);
    count_to_fetch("R7");
  endtask

  task automatic t_restart();
    enter_halt();
    rst_req = 1;
    step();
    drop_inputs();
    for (int i = 0; i < 20; i++) step();
    chk("R8", "still waiting", vec_fetch, 0);
    rst_req = 1;
    step();
    drop_inputs();
    count_to_fetch("R8");
  endtask

  task automatic t_rst_vs_irq();
    enter_halt();
    rst_req = 1; tmr_wake_irq = 1;
    step();
    drop_inputs();
    chk("R9", "no irq fetch", vec_fetch, 0);
    chk("R9", "clock still gated", cpu_clk_en, 0);
    count_to_fetch("R9");
  endtask

  task automatic t_pending();
    ahalt_en = 1; halt_exec = 1; irq_pend = 4'b1000;
    step();
    drop_inputs();
    chk("R10", "clock never dropped", cpu_clk_en, 1);
    chk("R10", "clr strobe", clr_imask, 1);
    chk("R10", "immediate fetch", vec_fetch, 1);
    chk("R10", "sel irq", vec_sel, 0);
    step();
    chk("R10", "stays running", cpu_clk_en, 1);
  endtask

  task automatic t_wdg();
    wdg_active = 1; wdg_halt_rst = 0;
    enter_halt();
    chk("R11", "no reset with bit clear", rst_out, 0);
    chk("R11", "sleeps with bit clear", cpu_clk_en, 0);
    tmr_wake_irq = 1;
    step();
    drop_inputs();
    step();
    wdg_halt_rst = 1; halt_exec = 1;
    step();
    drop_inputs();
    chk("R11", "reset pulse with bit set", rst_out, 1);
    chk("R11", "stays running with bit set", cpu_clk_en, 1);
    step();
    chk("R11", "reset pulse one cycle", rst_out, 0);
    wdg_active = 0; wdg_halt_rst = 0;
  endtask

  task automatic t_run_rst();
    ahalt_en = 1; halt_exec = 1; rst_req = 1;
    step();
    drop_inputs();
    chk("R12", "run reset keeps clock", cpu_clk_en, 1);
    chk("R12", "run reset no fetch/clr", {vec_fetch, clr_imask}, 0);
    for (int i = 0; i < DLY + 4; i++) begin
      step();
      if (vec_fetch) chk("R12", "late fetch", 1, 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step(); step();
    t_reset();
    t_disabled();
    t_enter_and_irq_exit();
    t_rst_exit();
    t_restart();
    t_rst_vs_irq();
    t_pending();
    t_wdg();
    t_run_rst();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule